// File: doc/BRIEF.md
# Transmit Collision Jam and Backoff Controller

This block sits beside a half-duplex Ethernet transmitter and decides what happens when the collision-detect input rises during an attempt. It forces an all-ones jam of fixed length onto the line. If the preamble is still going out, it holds the jam back until the preamble has finished. It then either schedules a retransmission after a random number of slot times or abandons the frame. All timing is counted in bit times through a one-cycle bit-clock enable.

The data path and FIFO handling live elsewhere and talk to this block through strobes. `tx_start` opens an attempt, `tx_done_ok` reports a clean finish, and `preamble_act` says the preamble is on the wire. In the other direction, `jam_active` tells the serializer to send ones, `retx_req` asks for the frame to be reloaded and sent again, and `tx_abort` reports that the frame is dropped.

The window check compares the bits sent since `tx_start` against one slot time. An early collision adds one to the retry count and starts a backoff. The backoff draws from a free-running LFSR, masked to 0 .. 2^min(n,BO_CAP)-1 slots. A late collision drops the frame and sets a sticky status. The collision after the limit-th retry drops the frame without backoff.

Top module: `txcol_ctrl`

## Requirements
- R1: After reset, jam_active, backoff_active, retx_req, tx_abort, owc_flag, excess_flag and tx_err are 0 and retry_cnt is 0.
- R2: A collision sampled while transmitting with preamble_act low raises jam_active in the next cycle. jam_active stays high for exactly JAM_BITS cycles in which bit_en is 1.
- R3: A collision sampled while preamble_act is 1 keeps jam_active low for as long as preamble_act stays 1. Jam starts the cycle after preamble_act is sampled 0 and still lasts JAM_BITS bit times.
- R4: A collision is in window when fewer than SLOT_BITS bit_en cycles have passed since tx_start was taken. At SLOT_BITS or more, it is late.
- R5: After a late collision's jam, tx_abort pulses for one cycle, owc_flag becomes 1, no backoff runs and retry_cnt returns to 0.
- R6: After the jam of the n-th consecutive in-window collision, with n ≤ RETRY_LIMIT, retry_cnt equals n. backoff_active is 1 and bo_slots is below 2^min(n,BO_CAP).
- R7: A backoff lasts bo_slots*SLOT_BITS bit times plus one final cycle. retx_req is 1 in exactly that final cycle, and backoff_active falls after it.
- R8: After the jam of collision number RETRY_LIMIT+1, tx_abort pulses, excess_flag becomes 1, no backoff runs and retry_cnt returns to 0.
- R9: tx_err equals owc_flag OR excess_flag. Both flags clear when a new tx_start is taken in idle.
- R10: tx_done_ok during transmission without a collision returns retry_cnt to 0.
- R11: col_det has no effect in idle and during backoff. No jam starts, retry_cnt is unchanged and the backoff length is unaltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle strobe per bit time |
| tx_start | input | 1 | Begin a transmit attempt (taken in idle) |
| tx_done_ok | input | 1 | Frame finished without collision |
| preamble_act | input | 1 | Preamble currently being sent |
| col_det | input | 1 | Collision detect |
| jam_active | output | 1 | Drive all-ones jam on the line |
| backoff_active | output | 1 | Backoff delay running |
| bo_slots | output | BO_CAP | Slot count drawn for the current backoff |
| retx_req | output | 1 | Request reload and retransmission of the frame |
| tx_abort | output | 1 | One-cycle pulse: frame dropped |
| owc_flag | output | 1 | Sticky out-of-window collision status |
| excess_flag | output | 1 | Sticky retry-limit status |
| tx_err | output | 1 | Transmit error (either status flag) |
| retry_cnt | output | $clog2(RETRY_LIMIT+2) | Collisions counted for the current frame |

## Verification
The hardest state to reach is the abort after the retry limit. It needs sixteen back-to-back in-window collisions, and each one must sit through a random backoff whose length the bench cannot predict. The bench runs with a four-bit slot so the longest draws stay short. For each draw it reads bo_slots and checks it against the 2^min(n,10) bound. It then times the backoff from the drawn value, so every retry level from 1 to 16 is covered before the seventeenth collision. The slot boundary is hit exactly by sweeping the collision point across SLOT_BITS-1 and SLOT_BITS bit times after start.

// File: rtl/txcol_pkg.sv
package txcol_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XMIT,
    ST_PREWAIT,
    ST_JAM,
    ST_BACKOFF
  } txcol_state_e;

  // exponent of the backoff range: min(n, cap)
  function automatic int unsigned bo_exp(input int unsigned n, input int unsigned cap);
    return (n < cap) ? n : cap;
  endfunction

  // bit i of the draw mask is set when i lies below the exponent
  function automatic logic bo_mask_bit(input int unsigned i, input int unsigned n,
                                       input int unsigned cap);
    return i < bo_exp(n, cap);
  endfunction

endpackage

// File: rtl/txcol_lfsr.sv
module txcol_lfsr #(
  parameter int unsigned          W     = 16,
  parameter int unsigned          OUT_W = 10,
  parameter logic [W-1:0]         SEED  = 'hACE1,
  parameter logic [W-1:0]         TAPS  = 'hB400
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] draw
);
  logic [W-1:0] q;
  logic         fb;

  assign fb   = ^(q & TAPS);
  assign draw = q[OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) q <= SEED;
    else        q <= {q[W-2:0], fb};
  end

  // a nonzero seed with the top tap set never collapses to zero
  p_lfsr_live_r6: assert property (@(posedge clk) disable iff (!rst_n) q != '0);
endmodule

// File: rtl/txcol_window.sv
module txcol_window #(
  parameter int unsigned SLOT_BITS = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic bit_en,
  output logic late
);
  localparam int unsigned      CW     = $clog2(SLOT_BITS + 1);
  localparam logic [CW-1:0]    SLOT_V = CW'(SLOT_BITS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                                  cnt <= '0;
    else if (clear)                              cnt <= '0;
    else if (run && bit_en && (cnt != SLOT_V))   cnt <= cnt + CW'(1);
  end

  assign late = (cnt == SLOT_V);

  // once past the slot, the attempt stays late until the next start
  p_late_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (late && !clear) |=> late);
endmodule

// File: rtl/txcol_backoff.sv
module txcol_backoff
  import txcol_pkg::*;
#(
  parameter int unsigned SLOT_BITS = 512,
  parameter int unsigned CAP       = 10,
  parameter int unsigned NW        = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bit_en,
  input  logic           load,
  input  logic [CAP-1:0] draw,
  input  logic [NW-1:0]  n,
  output logic           active,
  output logic [CAP-1:0] slots,
  output logic           done
);
  localparam int unsigned     SW        = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;
  localparam logic [SW-1:0]   SLOT_LAST = SW'(SLOT_BITS - 1);

  logic [CAP-1:0] mask;
  logic [CAP-1:0] rem;
  logic [SW-1:0]  sc;
  logic           act_q;

  for (genvar i = 0; i < CAP; i++) begin : g_mask
    assign mask[i] = bo_mask_bit(i, 32'(n), CAP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      slots <= '0;
      rem   <= '0;
      sc    <= '0;
    end else if (load) begin
      act_q <= 1'b1;
      slots <= draw & mask;
      rem   <= draw & mask;
      sc    <= '0;
    end else if (act_q) begin
      if (rem == '0) begin
        act_q <= 1'b0;
      end else if (bit_en) begin
        if (sc == SLOT_LAST) begin
          sc  <= '0;
          rem <= rem - CAP'(1);
        end else begin
          sc <= sc + SW'(1);
        end
      end
    end
  end

  assign active = act_q;
  assign done   = act_q && (rem == '0);

  // drawn count stays inside the range allowed for the retry level
  p_bo_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ((slots & ~mask) == '0));
  // the retransmit request closes the backoff
  p_done_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> !active);
  // remaining count never grows while the backoff runs
  p_rem_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !load) |=> (rem <= $past(rem)));
endmodule

// File: rtl/txcol_ctrl.sv
module txcol_ctrl
  import txcol_pkg::*;
#(
  parameter int unsigned SLOT_BITS   = 512,
  parameter int unsigned JAM_BITS    = 32,
  parameter int unsigned RETRY_LIMIT = 16,
  parameter int unsigned BO_CAP      = 10,
  parameter int unsigned LFSR_W      = 16
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   bit_en,
  input  logic                                   tx_start,
  input  logic                                   tx_done_ok,
  input  logic                                   preamble_act,
  input  logic                                   col_det,
  output logic                                   jam_active,
  output logic                                   backoff_active,
  output logic [BO_CAP-1:0]                      bo_slots,
  output logic                                   retx_req,
  output logic                                   tx_abort,
  output logic                                   owc_flag,
  output logic                                   excess_flag,
  output logic                                   tx_err,
  output logic [$clog2(RETRY_LIMIT+2)-1:0]       retry_cnt
);
  localparam int unsigned   RW       = $clog2(RETRY_LIMIT + 2);
  localparam int unsigned   JW       = (JAM_BITS > 1) ? $clog2(JAM_BITS) : 1;
  localparam logic [JW-1:0] JAM_LAST = JW'(JAM_BITS - 1);
  localparam logic [RW-1:0] LIMIT_V  = RW'(RETRY_LIMIT);

  txcol_state_e  st;
  logic [JW-1:0] jcnt;
  logic [RW-1:0] retry_q;
  logic [RW-1:0] retry_nxt;
  logic [RW-1:0] bo_n;
  logic          late_q;
  logic          owc_q, exc_q, abort_q;

  // named events
  logic start_take, col_hit, jam_last, over_limit;
  logic go_backoff, go_late_abort, go_excess_abort, done_ok;
  logic win_late, bo_done, bo_act;
  logic [BO_CAP-1:0] lfsr_draw;

  assign start_take      = (st == ST_IDLE) && tx_start;
  assign col_hit         = (st == ST_XMIT) && col_det;
  assign done_ok         = (st == ST_XMIT) && !col_det && tx_done_ok;
  assign jam_last        = (st == ST_JAM) && bit_en && (jcnt == JAM_LAST);
  assign retry_nxt       = retry_q + RW'(1);
  assign over_limit      = retry_nxt > LIMIT_V;
  assign go_late_abort   = jam_last && late_q;
  assign go_excess_abort = jam_last && !late_q && over_limit;
  assign go_backoff      = jam_last && !late_q && !over_limit;
  assign bo_n            = (st == ST_JAM) ? retry_nxt : retry_q;

  txcol_window #(.SLOT_BITS(SLOT_BITS)) u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (start_take),
    .run    (st == ST_XMIT),
    .bit_en (bit_en),
    .late   (win_late)
  );

  txcol_lfsr #(.W(LFSR_W), .OUT_W(BO_CAP)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .draw  (lfsr_draw)
  );

  txcol_backoff #(.SLOT_BITS(SLOT_BITS), .CAP(BO_CAP), .NW(RW)) u_backoff (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_en (bit_en),
    .load   (go_backoff),
    .draw   (lfsr_draw),
    .n      (bo_n),
    .active (bo_act),
    .slots  (bo_slots),
    .done   (bo_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      jcnt    <= '0;
      retry_q <= '0;
      late_q  <= 1'b0;
      owc_q   <= 1'b0;
      exc_q   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      abort_q <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (tx_start) begin
            st    <= ST_XMIT;
            owc_q <= 1'b0;
            exc_q <= 1'b0;
          end
        end
        ST_XMIT: begin
          if (col_det) begin
            jcnt   <= '0;
            late_q <= win_late;
            st     <= preamble_act ? ST_PREWAIT : ST_JAM;
          end else if (tx_done_ok) begin
            retry_q <= '0;
            st      <= ST_IDLE;
          end
        end
        ST_PREWAIT: begin
          if (!preamble_act) st <= ST_JAM;
        end
        ST_JAM: begin
          if (bit_en) jcnt <= jcnt + JW'(1);
          if (go_late_abort) begin
            owc_q   <= 1'b1;
            abort_q <= 1'b1;
            retry_q <= '0;
            st      <= ST_IDLE;
          end else if (go_excess_abort) begin
            exc_q   <= 1'b1;
            abort_q <= 1'b1;
            retry_q <= '0;
            st      <= ST_IDLE;
          end else if (go_backoff) begin
            retry_q <= retry_nxt;
            st      <= ST_BACKOFF;
          end
        end
        ST_BACKOFF: begin
          if (bo_done) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign jam_active     = (st == ST_JAM);
  assign backoff_active = bo_act;
  assign retx_req       = bo_done;
  assign tx_abort       = abort_q;
  assign owc_flag       = owc_q;
  assign excess_flag    = exc_q;
  assign tx_err         = owc_q | exc_q;
  assign retry_cnt      = retry_q;

  // R2: jam follows a collision outside the preamble
  p_jam_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (col_hit && !preamble_act) |=> jam_active);
  // R3: no jam while the preamble is still going out
  p_pre_defer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_PREWAIT) && preamble_act) |=> !jam_active);
  // R5: late collision aborts with no backoff
  p_owc_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(owc_flag) |-> (tx_abort && !backoff_active && retry_cnt == '0));
  // R8: retry exhaustion aborts with no backoff
  p_excess_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(excess_flag) |-> (tx_abort && !backoff_active && retry_cnt == '0));
  // R6: backoff only with a count inside the limit
  p_retry_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    backoff_active |-> (retry_cnt != '0 && retry_cnt <= LIMIT_V));
  // R10: clean completion clears the retry count
  p_done_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |=> (retry_cnt == '0));
  // R11: collisions in idle or backoff start nothing
  p_ignore_col_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (((st == ST_IDLE) && !tx_start) || (st == ST_BACKOFF)) |=> !jam_active);
  // R7: jam and backoff never overlap
  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(jam_active && backoff_active));
endmodule

// File: tb/txcol_ctrl_tb.sv
module txcol_ctrl_tb_top;
  localparam int SLOT  = 4;
  localparam int JAM   = 32;
  localparam int LIMIT = 16;
  localparam int CAP   = 10;
  localparam int RW    = $clog2(LIMIT + 2);

  logic clk = 1'b0;
  logic rst_n, bit_en, tx_start, tx_done_ok, preamble_act, col_det;
  logic jam_active, backoff_active, retx_req, tx_abort, owc_flag, excess_flag, tx_err;
  logic [CAP-1:0] bo_slots;
  logic [RW-1:0]  retry_cnt;

  int checks = 0;
  int errors = 0;
  bit half = 0;
  bit finished = 0;
  int exp_retry = 0;

  always #5 clk = ~clk;

  txcol_ctrl #(.SLOT_BITS(SLOT), .JAM_BITS(JAM), .RETRY_LIMIT(LIMIT), .BO_CAP(CAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_start(tx_start), .tx_done_ok(tx_done_ok),
    .preamble_act(preamble_act), .col_det(col_det), .jam_active(jam_active),
    .backoff_active(backoff_active), .bo_slots(bo_slots), .retx_req(retx_req),
    .tx_abort(tx_abort), .owc_flag(owc_flag), .excess_flag(excess_flag), .tx_err(tx_err),
    .retry_cnt(retry_cnt));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    bit_en = half ? ~bit_en : 1'b1;
  endtask

  function automatic int bo_limit(input int n);
    int e;
    e = (n < CAP) ? n : CAP;
    return 1 << e;
  endfunction

  task automatic attempt(input int k, input bit pre, input bit poke,
                         output int jam_len, output int abort_seen,
                         output int bo, output int bo_len, output int retx_at);
    int guard;
    preamble_act = pre;
    tx_start = 1'b1; tick(); tx_start = 1'b0;
    repeat (k) tick();
    col_det = 1'b1; tick(); col_det = 1'b0;
    if (pre) begin
      for (int i = 0; i < 4; i++) begin
        chk("R3 jam held during preamble", jam_active, 0);
        tick();
      end
      preamble_act = 1'b0;
      tick();
    end
    jam_len = 0; guard = 0;
    while (jam_active && guard < 10000) begin
      if (bit_en) jam_len++;
      guard++;
      tick();
    end
    abort_seen = tx_abort;
    bo = -1; bo_len = 0; retx_at = -1;
    if (backoff_active) begin
      bo = bo_slots;
      while (backoff_active && bo_len < 100000) begin
        if (retx_req) retx_at = bo_len;
        col_det = (poke && bo_len == 0);
        if (poke && bo_len > 0) chk("R11 no jam in backoff", jam_active, 0);
        bo_len++;
        tick();
      end
      col_det = 1'b0;
    end
    preamble_act = 1'b0;
  endtask

  task automatic check_inwin(input string tag, input int jl, input int ab, input int bo,
                             input int bl, input int ra);
    exp_retry++;
    chk({tag, " R2 jam length"}, jl, JAM);
    chk({tag, " R4 no abort in window"}, ab, 0);
    chk({tag, " R6 retry count"}, retry_cnt, exp_retry);
    chk({tag, " R6 backoff in range"}, (bo >= 0 && bo < bo_limit(exp_retry)) ? 1 : 0, 1);
    chk({tag, " R7 backoff length"}, bl, bo * SLOT + 1);
    chk({tag, " R7 retx in last cycle"}, ra, bo * SLOT);
  endtask

  task automatic finish_frame();
    tx_start = 1'b1; tick(); tx_start = 1'b0;
    tick();
    tx_done_ok = 1'b1; tick(); tx_done_ok = 1'b0;
    tick();
    exp_retry = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int jl, ab, bo, bl, ra;
    rst_n = 0; bit_en = 1; tx_start = 0; tx_done_ok = 0; preamble_act = 0; col_det = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();

    // R1 reset state
    chk("R1 jam_active", jam_active, 0);
    chk("R1 backoff_active", backoff_active, 0);
    chk("R1 retx_req", retx_req, 0);
    chk("R1 tx_abort", tx_abort, 0);
    chk("R1 tx_err", tx_err, 0);
    chk("R1 owc/excess", {owc_flag, excess_flag}, 0);
    chk("R1 retry_cnt", retry_cnt, 0);

    // R11 collision in idle
    col_det = 1; tick(); col_det = 0;
    for (int i = 0; i < 3; i++) begin
      chk("R11 no jam in idle", jam_active, 0);
      tick();
    end
    chk("R11 retry unchanged in idle", retry_cnt, 0);

    // R4 sweep of the collision point across the slot boundary
    for (int k = 0; k <= SLOT + 1; k++) begin
      attempt(k, 0, 0, jl, ab, bo, bl, ra);
      if (k < SLOT) begin
        check_inwin($sformatf("k=%0d", k), jl, ab, bo, bl, ra);
      end else begin
        chk("R2 jam length late", jl, JAM);
        chk("R4/R5 late abort pulse", ab, 1);
        chk("R5 owc_flag", owc_flag, 1);
        chk("R5 no backoff", bo, -1);
        chk("R5 retry cleared", retry_cnt, 0);
        chk("R9 tx_err from owc", tx_err, 1);
        tick();
        chk("R5 abort one cycle", tx_abort, 0);
        exp_retry = 0;
      end
    end

    // R9 new start clears the status
    tx_start = 1; tick(); tx_start = 0;
    chk("R9 owc cleared on start", owc_flag, 0);
    chk("R9 tx_err cleared", tx_err, 0);
    tick();
    tx_done_ok = 1; tick(); tx_done_ok = 0; tick();

    // R10 clean completion clears retries
    attempt(1, 0, 0, jl, ab, bo, bl, ra);
    check_inwin("R10 pre", jl, ab, bo, bl, ra);
    finish_frame();
    chk("R10 retry cleared on done", retry_cnt, 0);

    // R3 collision in preamble
    attempt(1, 1, 0, jl, ab, bo, bl, ra);
    chk("R3 jam length after preamble", jl, JAM);
    check_inwin("R3", jl, ab, bo, bl, ra);
    finish_frame();

    // R11 collision during backoff
    attempt(0, 0, 1, jl, ab, bo, bl, ra);
    check_inwin("R11", jl, ab, bo, bl, ra);
    chk("R11 retry unchanged after backoff poke", retry_cnt, 1);
    finish_frame();

    // R2 jam counts bit times at half rate (late collision)
    half = 1;
    attempt(3 * SLOT + 2, 0, 0, jl, ab, bo, bl, ra);
    chk("R2 jam length at half rate", jl, JAM);
    chk("R5 half-rate late abort", ab, 1);
    half = 0;
    tick();
    exp_retry = 0;

    // R8 retry exhaustion across every retry level
    for (int n = 1; n <= LIMIT + 1; n++) begin
      attempt(0, 0, 0, jl, ab, bo, bl, ra);
      if (n <= LIMIT) begin
        check_inwin($sformatf("n=%0d", n), jl, ab, bo, bl, ra);
      end else begin
        chk("R8 abort pulse", ab, 1);
        chk("R8 excess_flag", excess_flag, 1);
        chk("R8 no backoff", bo, -1);
        chk("R8 retry cleared", retry_cnt, 0);
        chk("R9 tx_err from excess", tx_err, 1);
        chk("R8 owc not set", owc_flag, 0);
      end
    end
    tx_start = 1; tick(); tx_start = 0;
    chk("R9 excess cleared on start", excess_flag, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule